// File: doc/BRIEF.md
# Folded-Symmetry Decimating FIR Engine

This block is a decimate-by-two FIR filter for a single real sample stream. Every accepted input sample is written into a 62-entry circular sample store. On the second sample of each pair, the block starts one multiply-accumulate pass. The pass walks a set of unique coefficients, one per clock. Each coefficient is applied to one stored sample, or to the pre-added sum of two stored samples, so a symmetric response costs one multiply per unique coefficient and not one per tap.

The coefficients sit in a shared 64-word RAM that has its own write port. A configuration word picks the base address of the active set, the count of unique coefficients and one of four response shapes. The configuration is captured when a pass starts. The result is rounded, shifted down by 15 bits and saturated to 16 bits, then presented with a one-cycle valid pulse.

Top module: `fir_decim_engine`

## Requirements
- R1: After synchronous reset, `out_valid`, `overrun` and `out_data` are 0, the pair phase is cleared, and every stored sample reads as 0 in the passes that follow.
- R2: The block gives one output for every two accepted samples (`in_valid` high at a rising edge). The pass starts on the second sample of each pair, counting from reset.
- R3: If the edge that accepts the second sample of a pair is E, `out_valid` is high for exactly one cycle, starting at edge E+NCOEFF+1 (NCOEFF = `cfg_ncoef` captured at E).
- R4: Mode 00 (odd symmetric, length 2·NCOEFF−1): the output equals the direct-form sum in which tap i and tap 2(NCOEFF−1)−i both take coefficient i. Age 0 is the newest sample.
- R5: Mode 01 (even symmetric, length 2·NCOEFF): tap i and tap 2·NCOEFF−1−i both take coefficient i.
- R6: Mode 10 (halfband, length 4(NCOEFF−1)+1): tap 2i and tap 4(NCOEFF−1)−2i take coefficient i, and every odd tap is zero.
- R7: Mode 11 (arbitrary, length NCOEFF): tap i takes coefficient i.
- R8: Coefficient i of a pass is read from RAM address (`cfg_base`+i) mod 64. A word written through `coef_we`/`coef_waddr`/`coef_wdata` is used by every later pass.
- R9: The output is floor((acc + 2^14) / 2^15), where acc is the exact sum of sample × coefficient products. Samples and coefficients are signed 16-bit, and coefficients are Q15.
- R10: A rounded result above 32767 gives 32767, and one below −32768 gives −32768.
- R11: If the second sample of a pair is accepted while a pass is running, `overrun` goes high and stays high until reset. That pair starts no pass, and the running pass completes unchanged.
- R12: Base, count and mode are captured at the start of a pass. Changes to `cfg_*` during a pass affect only later passes.
- R13: Responses up to 62 taps use the last 62 accepted samples correctly after the circular store has wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coef_we | input | 1 | Coefficient RAM write enable |
| coef_waddr | input | 6 | Coefficient RAM write address |
| coef_wdata | input | 16 | Coefficient word, signed Q15 |
| cfg_base | input | 6 | Address of the first unique coefficient |
| cfg_ncoef | input | 6 | Number of unique coefficients, 1 or more |
| cfg_mode | input | 2 | 00 odd, 01 even, 10 halfband, 11 arbitrary |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | 16 | Rounded, saturated signed output |
| overrun | output | 1 | Sticky flag: a pair completed while a pass was busy |

## Verification
The hardest case to reach from the ports is a pass that runs while new samples keep arriving. The incoming samples overwrite the store and complete a pair while the pass is still running. They must not disturb the pass in progress, yet they must appear in the pass after it. The stimulus gets there by pushing a pair and then two more samples on consecutive edges. It checks that the first result is unchanged, that no extra result appears and that the flag stays set. A further pair is then checked against a reference whose history includes the overlapping samples. A second hard case is changing the configuration on the cycle after a pass starts. Here the bench checks that both the result and the output timing follow the old settings.

// File: rtl/fir_decim_pkg.sv
// Package: shared constants and the response-shape encoding for the
// decimating FIR engine. Assumes 2-bit mode codes fixed by the control word.
package fir_decim_pkg;
    typedef enum logic [1:0] {
        SHAPE_ODD  = 2'b00,
        SHAPE_EVEN = 2'b01,
        SHAPE_HALF = 2'b10,
        SHAPE_ARB  = 2'b11
    } fir_shape_e;

    localparam int DEF_DATA_W     = 16;
    localparam int DEF_COEF_W     = 16;
    localparam int DEF_COEF_DEPTH = 64;
    localparam int DEF_TAP_MAX    = 62;
    localparam int DEF_FRAC       = 15;
endpackage

// File: rtl/fir_coef_ram.sv
// Coefficient store: single write port, asynchronous read port.
// Assumes DEPTH is a power of two so the address wraps naturally.
module fir_coef_ram #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store a coefficient word on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Combinational read of the coefficient addressed this cycle.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/fir_sample_ring.sv
// Circular sample store. Every strobe writes at wr_ptr and advances it.
// Two read ports return the sample of a given age relative to a head index
// (age 0 = sample stored at head). Ages at or beyond DEPTH are out of
// contract. Reset clears the contents so early passes see zeros.
module fir_sample_ring #(
    parameter int DEPTH = 62,
    parameter int W     = 16,
    parameter int AGE_W = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int IW   = (AGE_W > PW ? AGE_W : PW) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    output logic [PW-1:0]    wr_ptr,
    input  logic [PW-1:0]    head,
    input  logic [AGE_W-1:0] age [2],
    output logic [W-1:0]     rd_data [2]
);
    logic [W-1:0] mem [DEPTH];

    // Write the incoming sample and advance the pointer with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_ptr] <= wr_data;
            wr_ptr      <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_port
        logic [IW-1:0] h_ext, a_ext, idx;
        // Convert an age into a slot index modulo DEPTH and read it.
        always_comb begin
            h_ext = IW'(head);
            a_ext = IW'(age[p]);
            idx   = (h_ext >= a_ext) ? h_ext - a_ext : h_ext + IW'(DEPTH) - a_ext;
            rd_data[p] = (idx < IW'(DEPTH)) ? mem[idx[PW-1:0]] : '0;
        end
    end
endmodule

// File: rtl/fir_tap_sequencer.sv
// Maps a pass step k and the unique-coefficient count n onto the ages of the
// one or two samples that share coefficient k, per response shape.
// Assumes n >= 1 and a realised length no larger than the sample store.
module fir_tap_sequencer
    import fir_decim_pkg::*;
#(
    parameter int CNT_W = 6,
    localparam int AGE_W = CNT_W + 2
) (
    input  fir_shape_e       shape,
    input  logic [CNT_W-1:0] k,
    input  logic [CNT_W-1:0] n,
    output logic [AGE_W-1:0] age_a,
    output logic [AGE_W-1:0] age_b,
    output logic             pair_en
);
    logic [AGE_W-1:0] kk, nn;

    // Choose the sample ages for step k of the selected shape.
    always_comb begin
        kk = AGE_W'(k);
        nn = AGE_W'(n);
        age_a   = kk;
        age_b   = '0;
        pair_en = 1'b0;
        unique case (shape)
            SHAPE_ODD: begin
                age_b   = (nn << 1) - AGE_W'(2) - kk;
                pair_en = (kk != nn - AGE_W'(1));
            end
            SHAPE_EVEN: begin
                age_b   = (nn << 1) - AGE_W'(1) - kk;
                pair_en = 1'b1;
            end
            SHAPE_HALF: begin
                age_a   = kk << 1;
                age_b   = (nn << 2) - AGE_W'(4) - (kk << 1);
                pair_en = (kk != nn - AGE_W'(1));
            end
            SHAPE_ARB: begin
                pair_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fir_decim_engine.sv
// Top: decimate-by-two FIR engine with folded symmetric addressing.
// Every second accepted sample starts a pass of NCOEFF steps. Each step reads
// one coefficient and one or two samples, and the samples are pre-added
// before a registered multiply. A final stage rounds, shifts and saturates.
// Assumes the caller spaces pairs at least NCOEFF+1 cycles apart. A closer
// pair raises the sticky overrun flag and starts no pass.
module fir_decim_engine
    import fir_decim_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int COEF_W     = DEF_COEF_W,
    parameter int COEF_DEPTH = DEF_COEF_DEPTH,
    parameter int TAP_MAX    = DEF_TAP_MAX,
    parameter int FRAC       = DEF_FRAC,
    localparam int CADDR_W   = $clog2(COEF_DEPTH),
    localparam int CNT_W     = CADDR_W,
    localparam int SADDR_W   = $clog2(TAP_MAX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               coef_we,
    input  logic [CADDR_W-1:0] coef_waddr,
    input  logic [COEF_W-1:0]  coef_wdata,
    input  logic [CADDR_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]   cfg_ncoef,
    input  logic [1:0]         cfg_mode,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic               overrun
);
    localparam int AGE_W  = CNT_W + 2;
    localparam int PRE_W  = DATA_W + 1;
    localparam int PROD_W = PRE_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(TAP_MAX);
    localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(1) << (FRAC - 1);
    localparam logic signed [ACC_W-1:0] SAT_MAX  = (ACC_W'(1) << (DATA_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] SAT_MIN  = -(ACC_W'(1) << (DATA_W - 1));

    logic               phase_q, busy_q;
    logic [CNT_W-1:0]   k_q, n_q;
    logic [CADDR_W-1:0] base_q;
    fir_shape_e         mode_q;
    logic [SADDR_W-1:0] head_q, wr_ptr;
    logic               pair_done, pass_start, last_step;

    assign pair_done  = in_valid & phase_q;
    assign pass_start = pair_done & ~busy_q;
    assign last_step  = ({1'b0, k_q} + (CNT_W + 1)'(1)) >= {1'b0, n_q};

    // Track which sample of the current pair is arriving.
    always_ff @(posedge clk) begin
        if (!rst_n)        phase_q <= 1'b0;
        else if (in_valid) phase_q <= ~phase_q;
    end

    // Raise the sticky flag when a pair completes during a busy pass.
    always_ff @(posedge clk) begin
        if (!rst_n)                   overrun <= 1'b0;
        else if (pair_done && busy_q) overrun <= 1'b1;
    end

    // Start a pass, capture the configuration and step through the coefficients.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            k_q    <= '0;
            n_q    <= '0;
            base_q <= '0;
            mode_q <= SHAPE_ODD;
            head_q <= '0;
        end else if (pass_start) begin
            busy_q <= 1'b1;
            k_q    <= '0;
            n_q    <= cfg_ncoef;
            base_q <= cfg_base;
            mode_q <= fir_shape_e'(cfg_mode);
            head_q <= wr_ptr;
        end else if (busy_q) begin
            k_q <= k_q + 1'b1;
            if (last_step) busy_q <= 1'b0;
        end
    end

    logic [AGE_W-1:0]  age_a, age_b;
    logic              pair_en;
    logic [AGE_W-1:0]  ages [2];
    logic [DATA_W-1:0] samp [2];
    logic [COEF_W-1:0] coef_rd;

    fir_tap_sequencer #(.CNT_W(CNT_W)) u_seq (
        .shape(mode_q), .k(k_q), .n(n_q),
        .age_a(age_a), .age_b(age_b), .pair_en(pair_en)
    );

    assign ages[0] = age_a;
    assign ages[1] = age_b;

    fir_sample_ring #(.DEPTH(TAP_MAX), .W(DATA_W), .AGE_W(AGE_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_data(in_data),
        .wr_ptr(wr_ptr), .head(head_q), .age(ages), .rd_data(samp)
    );

    fir_coef_ram #(.DEPTH(COEF_DEPTH), .W(COEF_W)) u_coef (
        .clk(clk), .we(coef_we), .waddr(coef_waddr), .wdata(coef_wdata),
        .raddr(base_q + CADDR_W'(k_q)), .rdata(coef_rd)
    );

    logic signed [PRE_W-1:0]  pre_sum;
    logic signed [PRE_W-1:0]  st_pre;
    logic signed [COEF_W-1:0] st_coef;
    logic                     st_vld, st_first, st_last;

    // Fold the symmetric pair into one operand ahead of the multiplier.
    always_comb begin
        pre_sum = PRE_W'($signed(samp[0]));
        if (pair_en) pre_sum = pre_sum + PRE_W'($signed(samp[1]));
    end

    // Register the operands of one step for the multiply-accumulate stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_vld   <= 1'b0;
            st_first <= 1'b0;
            st_last  <= 1'b0;
            st_pre   <= '0;
            st_coef  <= '0;
        end else begin
            st_vld   <= busy_q;
            st_first <= busy_q && (k_q == '0);
            st_last  <= busy_q && last_step;
            st_pre   <= pre_sum;
            st_coef  <= $signed(coef_rd);
        end
    end

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc_q, acc_next, rnd;

    // Form the product, accumulate it and round the running sum.
    always_comb begin
        prod     = st_pre * st_coef;
        acc_next = (st_first ? '0 : acc_q) + ACC_W'(prod);
        rnd      = (acc_next + RND_HALF) >>> FRAC;
    end

    // Hold the running sum and publish the saturated result at the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= st_vld && st_last;
            if (st_vld) acc_q <= acc_next;
            if (st_vld && st_last) begin
                if (rnd > SAT_MAX)      out_data <= SAT_MAX[DATA_W-1:0];
                else if (rnd < SAT_MIN) out_data <= SAT_MIN[DATA_W-1:0];
                else                    out_data <= rnd[DATA_W-1:0];
            end
        end
    end
endmodule

// File: rtl/fir_decim_checker.sv
// Checker: temporal properties of the decimating FIR engine, bound to the top.
module fir_decim_checker #(
    parameter int CNT_W   = 6,
    parameter int CADDR_W = 6,
    parameter int SADDR_W = 6,
    parameter int DEPTH   = 62
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               out_valid,
    input logic               overrun,
    input logic               phase_q,
    input logic               busy_q,
    input logic [1:0]         mode_q,
    input logic [CNT_W-1:0]   n_q,
    input logic [CADDR_W-1:0] base_q,
    input logic               st_vld,
    input logic               st_last,
    input logic [SADDR_W-1:0] wr_ptr
);
    // R3: the output strobe lasts a single cycle.
    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R3: the last product of a pass is followed by the output strobe.
    p_last_to_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vld && st_last) |=> out_valid);

    // R2: a completed pair with the engine idle starts a pass.
    p_pair_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && phase_q && !busy_q) |=> busy_q);

    // R11: a pair completing during a pass sets the flag.
    p_overrun_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && phase_q && busy_q) |=> overrun);

    // R11: the flag is sticky.
    p_overrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R12: the captured configuration is held for the whole pass.
    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> (!busy_q || ($stable(mode_q) && $stable(n_q) && $stable(base_q))));

    // R13: the write pointer stays inside the circular store.
    p_ptr_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr < SADDR_W'(DEPTH));
endmodule

bind fir_decim_engine fir_decim_checker #(
    .CNT_W(CNT_W), .CADDR_W(CADDR_W), .SADDR_W(SADDR_W), .DEPTH(TAP_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .overrun(overrun), .phase_q(phase_q), .busy_q(busy_q), .mode_q(mode_q),
    .n_q(n_q), .base_q(base_q), .st_vld(st_vld), .st_last(st_last),
    .wr_ptr(wr_ptr)
);

// File: tb/fir_decim_engine_bench.sv
// Directed bench for the decimating FIR engine with a direct-form reference.
module fir_decim_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        coef_we = 1'b0;
    logic [5:0]  coef_waddr = '0;
    logic [15:0] coef_wdata = '0;
    logic [5:0]  cfg_base = '0;
    logic [5:0]  cfg_ncoef = 6'd1;
    logic [1:0]  cfg_mode = 2'b00;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        overrun;

    int errors = 0;
    int checks = 0;
    int cm [64];
    int hist [$];
    int seed = 12345;

    fir_decim_engine u_fir_decim_engine (.*);

    always #5 clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FIL%s %s actual=%0d expected=%0d", "", req, act, exp);
        end
    endtask

    function automatic int next_sample();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return ((seed >>> 8) % 40001) - 20000;
    endfunction

    // Reference: expanded direct-form tap list applied to the sample history.
    function automatic longint ref_out();
        longint h [256];
        int n = int'(cfg_ncoef);
        int len;
        longint acc = 0;
        longint r;
        for (int i = 0; i < 256; i++) h[i] = 0;
        case (cfg_mode)
            2'b00: len = 2 * n - 1;
            2'b01: len = 2 * n;
            2'b10: len = 4 * (n - 1) + 1;
            default: len = n;
        endcase
        for (int k = 0; k < n; k++) begin
            longint c = cm[(int'(cfg_base) + k) % 64];
            case (cfg_mode)
                2'b00: begin h[k] = c; h[len - 1 - k] = c; end
                2'b01: begin h[k] = c; h[len - 1 - k] = c; end
                2'b10: begin h[2 * k] = c; h[len - 1 - 2 * k] = c; end
                default: h[k] = c;
            endcase
        end
        for (int i = 0; i < len; i++)
            if (i < hist.size()) acc += h[i] * hist[i];
        r = (acc + 16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic write_coef(input int addr, input int val);
        coef_we = 1'b1; coef_waddr = addr[5:0]; coef_wdata = val[15:0];
        cm[addr] = val;
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic set_cfg(input int base, input int n, input int mode);
        cfg_base = base[5:0]; cfg_ncoef = n[5:0]; cfg_mode = mode[1:0];
    endtask

    task automatic push(input int v);
        in_valid = 1'b1; in_data = v[15:0];
        @(negedge clk);
        in_valid = 1'b0;
        hist.push_front(v);
        if (hist.size() > 64) void'(hist.pop_back());
    endtask

    // Push one pair, check the strobe timing and the value against the model.
    task automatic run_pair(input int a, input int b, input string req);
        longint exp;
        int n;
        push(a);
        push(b);
        exp = ref_out();
        n = int'(cfg_ncoef);
        repeat (n) @(negedge clk);
        chk({req, " R3 no early strobe"}, out_valid, 0);
        @(negedge clk);
        chk({req, " R3 strobe"}, out_valid, 1);
        chk({req, " value"}, $signed(out_data), exp);
        @(negedge clk);
        chk({req, " R3 strobe width"}, out_valid, 0);
    endtask

    task automatic t_reset();
        chk("R1 out_valid", out_valid, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 out_data", out_data, 0);
        set_cfg(0, 4, 0);
        run_pair(1000, -2000, "R1 zero history");
    endtask

    task automatic t_mode(input int base, input int n, input int mode, input string req);
        set_cfg(base, n, mode);
        for (int p = 0; p < 3; p++) run_pair(next_sample(), next_sample(), req);
    endtask

    task automatic t_decim_r2();
        int cnt = 0;
        set_cfg(0, 3, 1);
        for (int i = 0; i < 6; i++) begin
            push(next_sample());
            repeat (5) begin
                if (out_valid) cnt++;
                @(negedge clk);
            end
        end
        chk("R2 outputs per six samples", cnt, 3);
    endtask

    task automatic t_base_r8();
        set_cfg(62, 4, 3);
        run_pair(next_sample(), next_sample(), "R8 base wrap");
        write_coef(63, -12345);
        run_pair(next_sample(), next_sample(), "R8 rewritten word");
    endtask

    task automatic t_round_r9();
        write_coef(40, 16384);
        set_cfg(40, 1, 3);
        run_pair(0, 1, "R9 0.5 up");
        chk("R9 hand value 0.5", $signed(out_data), 1);
        run_pair(0, 3, "R9 1.5 up");
        chk("R9 hand value 1.5", $signed(out_data), 2);
        run_pair(0, -1, "R9 -0.5 up");
        chk("R9 hand value -0.5", $signed(out_data), 0);
        run_pair(0, -3, "R9 -1.5 up");
        chk("R9 hand value -1.5", $signed(out_data), -1);
    endtask

    task automatic t_sat_r10();
        write_coef(41, 32767);
        write_coef(42, 32767);
        set_cfg(41, 2, 1);
        run_pair(32767, 32767, "R10 fill");
        run_pair(32767, 32767, "R10 positive");
        chk("R10 positive clip", $signed(out_data), 32767);
        run_pair(-32768, -32768, "R10 fill");
        run_pair(-32768, -32768, "R10 negative");
        chk("R10 negative clip", $signed(out_data), -32768);
    endtask

    task automatic t_full_r13();
        set_cfg(0, 31, 1);
        for (int p = 0; p < 40; p++) run_pair(next_sample(), next_sample(), "R13 62 taps");
        set_cfg(2, 16, 2);
        for (int p = 0; p < 4; p++) run_pair(next_sample(), next_sample(), "R13 61 halfband");
    endtask

    task automatic t_snapshot_r12();
        longint exp;
        set_cfg(0, 4, 0);
        push(next_sample());
        push(next_sample());
        exp = ref_out();
        set_cfg(30, 2, 3);
        repeat (4) @(negedge clk);
        chk("R12 old count timing", out_valid, 0);
        @(negedge clk);
        chk("R12 strobe", out_valid, 1);
        chk("R12 old config value", $signed(out_data), exp);
        @(negedge clk);
        run_pair(next_sample(), next_sample(), "R12 new config");
    endtask

    task automatic t_overrun_r11();
        longint exp;
        int extra = 0;
        chk("R11 flag clear before", overrun, 0);
        set_cfg(0, 4, 0);
        push(next_sample());
        push(next_sample());
        exp = ref_out();
        push(next_sample());
        push(next_sample());
        chk("R11 flag raised", overrun, 1);
        repeat (3) @(negedge clk);
        chk("R11 running pass strobe", out_valid, 1);
        chk("R11 running pass value", $signed(out_data), exp);
        @(negedge clk);
        repeat (8) begin
            if (out_valid) extra++;
            @(negedge clk);
        end
        chk("R11 dropped pass", extra, 0);
        run_pair(next_sample(), next_sample(), "R11 after overrun");
        chk("R11 flag sticky", overrun, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) write_coef(i, ((i * 7919 + 13) % 20001) - 10000);
        t_reset();
        t_mode(0, 4, 0, "R4 odd");
        t_mode(10, 5, 1, "R5 even");
        t_mode(20, 4, 2, "R6 halfband");
        t_mode(30, 7, 3, "R7 arbitrary");
        t_decim_r2();
        t_base_r8();
        t_round_r9();
        t_sat_r10();
        t_full_r13();
        t_snapshot_r12();
        t_overrun_r11();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule